// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one memory-to-memory copy channel that takes its work from a linked list of transfer descriptors in memory. Host software builds descriptors, writes the address of the first one into the channel, and sets the run bit. The channel reads the descriptor, copies the data one 32-bit word at a time with a read beat followed by a write beat, and then follows the descriptor's link to the next one until it meets a null link.

Each side of the copy can be held back by a peripheral request line picked from a bank of inputs, so the channel can feed or drain a slow peripheral without polling. The host can pause the channel between beats, skip the current descriptor, or reset the channel outright. Completion raises a flag and the interrupt line if the descriptor asks for it. Bus errors are kept in a small sticky log that software clears by writing ones.

Top module: `desc_dma_channel`

## Requirements
- R1: After reset every readable register is zero, `irq` is low and `mem_req` is low.
- R2: Writing a 32-byte aligned address to the descriptor-address register (offset 0x04) and then writing 1 to bit 0 (run) of the control/status register (offset 0x00) fetches six words from that address: info, source, destination, length, stride, next link. The transfer then starts. Writing run with a zero descriptor address leaves the channel idle.
- R3: Each beat reads one word from the source address and writes it to the destination address. The length (bytes, bits 1:0 ignored) drops by 4 per beat, and the descriptor is complete when it reaches zero. A zero length completes with no beats.
- R4: Control/status bit 1 (done) and bit 2 (interrupt flag) are cleared by writing 1 and unchanged by writing 0.
- R5: On completion the channel loads the next link as its descriptor address and fetches it. A zero link ends the chain, clears run and zeroes the descriptor address. Done (bit 1) is set at every completion.
- R6: Info bit 8 makes the source address advance by 4 per beat and info bit 4 does the same for the destination. With the bit clear the address stays fixed.
- R7: Info bit 10 paces source reads and bit 6 paces destination writes on request input `dreq[info[20:16]]`. A beat on a paced side is issued only while that input is high, and select 0 disables pacing. Control/status bit 3 shows the selected input's level. Bit 5 (held) shows the channel is running but waiting on pacing.
- R8: The interrupt flag is set at completion only when info bit 0 is set. `irq` is high while the interrupt flag or any error bit is set.
- R9: Clearing run while a transfer is in progress stops new bus requests after the current one finishes. Control/status bit 4 (paused) then reads 1. Setting run again resumes where it stopped.
- R10: Writing control/status bit 30 (skip) drops the current descriptor at the next beat boundary without writing its remaining data and without setting done. The channel continues with the next link.
- R11: A bus error response sets a bit in the error log at offset 0x20: bit 0 for a source read, bit 1 for a destination write, bit 2 for a descriptor fetch. It also stops the channel (run cleared) and shows as control/status bit 8. Log bits clear only by writing 1 to them.
- R12: Writing control/status bit 31 returns the channel at once to idle with all registers and the error log cleared.
- R13: Bits 4:0 of the descriptor address and of the next link are forced to zero. Writes to the descriptor address are ignored unless the channel is idle.
- R14: Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read back the current info, source address, destination address, remaining length, stride and next link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset within the channel bank |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the request, read data valid |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data |
| dreq | input | NUM_REQ | Peripheral pacing request lines |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume the memory side asserts `mem_ack` only while `mem_req` is high, and that the request lines need not be synchronous to anything but `clk`. The checks on held requests assume no channel reset is written while a request is outstanding. The bench's memory model answers each request one cycle after it appears and drops the acknowledge on the accepting edge. Every soft reset it issues happens while the channel is stalled on pacing with no request pending, so the assertions' input assumptions always hold.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE
    } dmac_state_e;

    localparam int unsigned DESC_FETCH_WORDS = 6;
    localparam int unsigned WIDX_W           = 3;
    localparam int unsigned REQ_SEL_W        = 5;
    localparam int unsigned ERR_BITS         = 3;

    // register offsets
    localparam logic [7:0] REG_CS     = 8'h00;
    localparam logic [7:0] REG_CBADDR = 8'h04;
    localparam logic [7:0] REG_INFO   = 8'h08;
    localparam logic [7:0] REG_SRC    = 8'h0C;
    localparam logic [7:0] REG_DST    = 8'h10;
    localparam logic [7:0] REG_LEN    = 8'h14;
    localparam logic [7:0] REG_STRIDE = 8'h18;
    localparam logic [7:0] REG_NEXT   = 8'h1C;
    localparam logic [7:0] REG_ERRLOG = 8'h20;

    // control/status bits
    localparam int unsigned CS_RUN     = 0;
    localparam int unsigned CS_DONE    = 1;
    localparam int unsigned CS_IFLAG   = 2;
    localparam int unsigned CS_REQLVL  = 3;
    localparam int unsigned CS_PAUSED  = 4;
    localparam int unsigned CS_HELD    = 5;
    localparam int unsigned CS_WAITING = 6;
    localparam int unsigned CS_ERR     = 8;
    localparam int unsigned CS_KEEP_LO = 28;
    localparam int unsigned CS_KEEP_HI = 29;
    localparam int unsigned CS_SKIP    = 30;
    localparam int unsigned CS_CLEAR   = 31;

    // info word bits
    localparam int unsigned INF_IRQ_EN = 0;
    localparam int unsigned INF_DINC   = 4;
    localparam int unsigned INF_DPACE  = 6;
    localparam int unsigned INF_SINC   = 8;
    localparam int unsigned INF_SPACE  = 10;
    localparam int unsigned INF_SEL_LO = 16;

    // error log bits
    localparam int unsigned ERR_RD    = 0;
    localparam int unsigned ERR_WR    = 1;
    localparam int unsigned ERR_FETCH = 2;

    typedef struct packed {
        dmac_state_e        st;
        logic               run;
        logic               done_f;
        logic               irq_f;
        logic               skip_pend;
        logic               req;
        logic               we;
        logic [WIDX_W-1:0]  widx;
        logic [1:0]         keep;
        logic [31:0]        cbaddr;
        logic [31:0]        info;
        logic [31:0]        src;
        logic [31:0]        dst;
        logic [31:0]        len;
        logic [31:0]        stride;
        logic [31:0]        nxt;
        logic [31:0]        addr;
        logic [31:0]        wdata;
        logic [31:0]        data;
    } eng_state_t;

endpackage

// File: rtl/dmac_pace.sv
module dmac_pace #(
    parameter int unsigned NUM_REQ = 32,
    parameter int unsigned SEL_W   = 5
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [SEL_W-1:0]   sel,
    input  logic               paced,
    output logic               go,
    output logic               level
);
    always_comb begin
        level = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (sel == SEL_W'(i)) level = req[i];
        end
        go = !paced || (sel == '0) || level;
    end
endmodule

// File: rtl/dmac_err_log.sv
module dmac_err_log #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         clr_all_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
        if (clr_all_i) flags_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    for (genvar g = 0; g < N; g++) begin : g_sticky
        assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(flags_q[g]) && !$past(clr_i[g]) && !$past(clr_all_i)) |-> flags_q[g]);
    end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_wen,
    input  logic                cb_wen,
    input  logic [31:0]         wdata,
    input  logic                src_go,
    input  logic                dst_go,
    output logic                mem_req,
    output logic                mem_we,
    output logic [31:0]         mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic                mem_ack,
    input  logic                mem_err,
    input  logic [31:0]         mem_rdata,
    output logic [ERR_BITS-1:0] err_set,
    output logic                soft_clr,
    output logic                run,
    output logic                done_f,
    output logic                irq_f,
    output logic                paused,
    output logic                held,
    output logic                waiting,
    output logic [1:0]          keep,
    output logic [31:0]         cbaddr,
    output logic [31:0]         info,
    output logic [31:0]         src,
    output logic [31:0]         dst,
    output logic [31:0]         len,
    output logic [31:0]         stride,
    output logic [31:0]         nxt
);
    localparam logic [WIDX_W-1:0] LAST_WIDX = WIDX_W'(DESC_FETCH_WORDS - 1);

    eng_state_t d, q;
    logic       finish, chain;
    logic       unused_bits;

    assign unused_bits = ^wdata[4:3];
    assign soft_clr    = cs_wen && wdata[CS_CLEAR];

    always_comb begin
        d       = q;
        err_set = '0;
        finish  = 1'b0;
        chain   = 1'b0;

        if (cs_wen) begin
            if (wdata[CS_DONE])  d.done_f = 1'b0;
            if (wdata[CS_IFLAG]) d.irq_f  = 1'b0;
            d.keep = wdata[CS_KEEP_HI:CS_KEEP_LO];
            if (wdata[CS_SKIP] && q.st != ST_IDLE) d.skip_pend = 1'b1;
            if (q.st == ST_IDLE) begin
                d.run = wdata[CS_RUN] && (q.cbaddr != '0);
                if (d.run) begin
                    d.st   = ST_FETCH;
                    d.widx = '0;
                end
            end else begin
                d.run = wdata[CS_RUN];
            end
        end

        if (cb_wen && q.st == ST_IDLE) d.cbaddr = {wdata[31:5], 5'd0};

        if (q.req) begin
            if (mem_ack) begin
                d.req = 1'b0;
                if (mem_err) begin
                    case (q.st)
                        ST_FETCH: err_set[ERR_FETCH] = 1'b1;
                        ST_READ:  err_set[ERR_RD]    = 1'b1;
                        ST_WRITE: err_set[ERR_WR]    = 1'b1;
                        default:  ;
                    endcase
                    d.st        = ST_IDLE;
                    d.run       = 1'b0;
                    d.skip_pend = 1'b0;
                end else begin
                    case (q.st)
                        ST_FETCH: begin
                            case (q.widx)
                                3'd0: d.info   = mem_rdata;
                                3'd1: d.src    = mem_rdata;
                                3'd2: d.dst    = mem_rdata;
                                3'd3: d.len    = {mem_rdata[31:2], 2'b00};
                                3'd4: d.stride = mem_rdata;
                                3'd5: d.nxt    = {mem_rdata[31:5], 5'd0};
                                default: ;
                            endcase
                            if (q.widx == LAST_WIDX) begin
                                if (q.len == '0) finish = 1'b1;
                                else             d.st   = ST_READ;
                            end else begin
                                d.widx = q.widx + 1'b1;
                            end
                        end
                        ST_READ: begin
                            d.data = mem_rdata;
                            d.st   = ST_WRITE;
                        end
                        ST_WRITE: begin
                            if (q.info[INF_SINC]) d.src = q.src + 32'd4;
                            if (q.info[INF_DINC]) d.dst = q.dst + 32'd4;
                            d.len = q.len - 32'd4;
                            if (q.len == 32'd4) finish = 1'b1;
                            else                d.st   = ST_READ;
                        end
                        default: ;
                    endcase
                end
            end
        end else if (q.st != ST_IDLE) begin
            if (q.skip_pend && q.st != ST_FETCH) begin
                chain = 1'b1;
            end else if (q.run) begin
                case (q.st)
                    ST_FETCH: begin
                        d.req  = 1'b1;
                        d.we   = 1'b0;
                        d.addr = q.cbaddr + {27'd0, q.widx, 2'b00};
                    end
                    ST_READ: if (src_go) begin
                        d.req  = 1'b1;
                        d.we   = 1'b0;
                        d.addr = q.src;
                    end
                    ST_WRITE: if (dst_go) begin
                        d.req   = 1'b1;
                        d.we    = 1'b1;
                        d.addr  = q.dst;
                        d.wdata = q.data;
                    end
                    default: ;
                endcase
            end
        end

        if (finish) begin
            d.done_f = 1'b1;
            if (d.info[INF_IRQ_EN]) d.irq_f = 1'b1;
            chain = 1'b1;
        end

        if (chain) begin
            d.skip_pend = 1'b0;
            d.widx      = '0;
            if (d.nxt == '0) begin
                d.st     = ST_IDLE;
                d.run    = 1'b0;
                d.cbaddr = '0;
            end else begin
                d.cbaddr = d.nxt;
                d.st     = ST_FETCH;
            end
        end

        if (soft_clr) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req   = q.req;
    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign run       = q.run;
    assign done_f    = q.done_f;
    assign irq_f     = q.irq_f;
    assign keep      = q.keep;
    assign cbaddr    = q.cbaddr;
    assign info      = q.info;
    assign src       = q.src;
    assign dst       = q.dst;
    assign len       = q.len;
    assign stride    = q.stride;
    assign nxt       = q.nxt;
    assign waiting   = q.req;
    assign paused    = !q.run && (q.st != ST_IDLE) && !q.req;
    assign held      = q.run && !q.req &&
                       ((q.st == ST_READ && !src_go) || (q.st == ST_WRITE && !dst_go));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.req);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req && !mem_ack && !soft_clr) |=> (q.req && $stable(q.addr) && $stable(q.we)));

    assert_len_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WRITE) |-> (q.len != '0));

    assert_paced_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.req) && !q.we && q.st == ST_READ) |-> $past(src_go));

    assert_paced_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.req) && q.we) |-> $past(dst_go));

    assert_no_issue_paused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.req) |-> $past(q.run));
endmodule

// File: rtl/desc_dma_channel.sv
module desc_dma_channel
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_REQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         reg_addr,
    input  logic               reg_wen,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic               mem_err,
    input  logic [31:0]        mem_rdata,
    input  logic [NUM_REQ-1:0] dreq,
    output logic               irq
);
    localparam int unsigned NUM_SIDES = 2;

    logic                cs_wen, cb_wen, log_wen;
    logic [ERR_BITS-1:0] err_set, err_flags, err_clr;
    logic                soft_clr;
    logic                run, done_f, irq_f, paused, held, waiting;
    logic [1:0]          keep;
    logic [31:0]         cbaddr, info, src, dst, len, stride, nxt;
    logic [NUM_SIDES-1:0] side_go, side_lvl;
    logic                unused_lvl;
    logic [31:0]         cs_word;

    assign cs_wen  = reg_wen && (reg_addr == REG_CS);
    assign cb_wen  = reg_wen && (reg_addr == REG_CBADDR);
    assign log_wen = reg_wen && (reg_addr == REG_ERRLOG);
    assign err_clr = log_wen ? reg_wdata[ERR_BITS-1:0] : '0;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int unsigned PACE_BIT = (s == 0) ? INF_SPACE : INF_DPACE;
        dmac_pace #(.NUM_REQ(NUM_REQ), .SEL_W(REQ_SEL_W)) i_pace (
            .req   (dreq),
            .sel   (info[INF_SEL_LO +: REQ_SEL_W]),
            .paced (info[PACE_BIT]),
            .go    (side_go[s]),
            .level (side_lvl[s])
        );
    end
    assign unused_lvl = side_lvl[1];

    dmac_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_wen    (cs_wen),
        .cb_wen    (cb_wen),
        .wdata     (reg_wdata),
        .src_go    (side_go[0]),
        .dst_go    (side_go[1]),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .err_set   (err_set),
        .soft_clr  (soft_clr),
        .run       (run),
        .done_f    (done_f),
        .irq_f     (irq_f),
        .paused    (paused),
        .held      (held),
        .waiting   (waiting),
        .keep      (keep),
        .cbaddr    (cbaddr),
        .info      (info),
        .src       (src),
        .dst       (dst),
        .len       (len),
        .stride    (stride),
        .nxt       (nxt)
    );

    dmac_err_log #(.N(ERR_BITS)) i_err_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (err_set),
        .clr_i     (err_clr),
        .clr_all_i (soft_clr),
        .flags_o   (err_flags)
    );

    always_comb begin
        cs_word                        = '0;
        cs_word[CS_RUN]                = run;
        cs_word[CS_DONE]               = done_f;
        cs_word[CS_IFLAG]              = irq_f;
        cs_word[CS_REQLVL]             = side_lvl[0];
        cs_word[CS_PAUSED]             = paused;
        cs_word[CS_HELD]               = held;
        cs_word[CS_WAITING]            = waiting;
        cs_word[CS_ERR]                = |err_flags;
        cs_word[CS_KEEP_HI:CS_KEEP_LO] = keep;
    end

    always_comb begin
        case (reg_addr)
            REG_CS:     reg_rdata = cs_word;
            REG_CBADDR: reg_rdata = cbaddr;
            REG_INFO:   reg_rdata = info;
            REG_SRC:    reg_rdata = src;
            REG_DST:    reg_rdata = dst;
            REG_LEN:    reg_rdata = len;
            REG_STRIDE: reg_rdata = stride;
            REG_NEXT:   reg_rdata = nxt;
            REG_ERRLOG: reg_rdata = {{(32-ERR_BITS){1'b0}}, err_flags};
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = irq_f || (|err_flags);

    assert_irq_follows_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |=> irq);
endmodule

// File: tb/test_desc_dma_channel.sv
module test_desc_dma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] dreq = '0;
    logic        irq;

    logic [31:0] mem [0:1023];
    logic [63:0] exp_q [$];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
    bit wd_hit = 1'b0;

    always #5 clk = ~clk;

    desc_dma_channel i_desc_dma_channel (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .dreq(dreq), .irq(irq)
    );

    // memory model and write monitor (scoreboard consumer)
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req && mem_ack) begin
            if (mem_we && !mem_err) begin
                mon_chk++;
                if (exp_q.size() == 0) begin
                    mon_fail++;
                    $display("FAIL R3 unexpected write: actual %h@%h expected none", mem_wdata, mem_addr);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    if ({mem_addr, mem_wdata} !== e) begin
                        mon_fail++;
                        $display("FAIL R3 write beat: actual %h@%h expected %h@%h",
                                 mem_wdata, mem_addr, e[31:0], e[63:32]);
                    end
                end
            end
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req) begin
            mem_ack   <= 1'b1;
            mem_err   <= (mem_addr == err_addr);
            mem_rdata <= mem[mem_addr[11:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic report();
        int c, f;
        c = n_chk + mon_chk + (wd_hit ? 1 : 0);
        f = n_fail + mon_fail + (wd_hit ? 1 : 0);
        $display("End of test - %0d assertions evaluated, %0d failures", c, f);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] inf,
                            input logic [31:0] s, input logic [31:0] dd,
                            input logic [31:0] l, input logic [31:0] nx);
        mem[base[11:2] + 0] = inf;
        mem[base[11:2] + 1] = s;
        mem[base[11:2] + 2] = dd;
        mem[base[11:2] + 3] = l;
        mem[base[11:2] + 4] = 32'h0000_0055;
        mem[base[11:2] + 5] = nx;
    endtask

    // scoreboard producer
    task automatic exp_copy(input logic [31:0] s, input logic [31:0] dd,
                            input int nbytes, input bit sinc, input bit dinc);
        logic [31:0] sa, da;
        sa = s; da = dd;
        for (int i = 0; i < nbytes / 4; i++) begin
            exp_q.push_back({da, mem[sa[11:2]]});
            if (sinc) sa += 4;
            if (dinc) da += 4;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(8'h00, v);
            if (!v[0]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic start(input logic [31:0] desc);
        wr(8'h04, desc);
        wr(8'h00, 32'h1);
    endtask

    localparam logic [31:0] INC2  = 32'h0000_0110;
    localparam logic [31:0] IEN   = 32'h0000_0001;

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 cs after reset", v, 32'h0);
        rd(8'h04, v); chk("R1 desc addr after reset", v, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);
        chk("R1 mem_req after reset", {31'd0, mem_req}, 32'h0);

        // R2 run with null descriptor address stays idle
        wr(8'h00, 32'h1);
        rd(8'h00, v); chk("R2 run with zero address", v[0], 1'b0);

        // R13 alignment of descriptor address
        wr(8'h04, 32'h0000_013F);
        rd(8'h04, v); chk("R13 desc addr low bits", v, 32'h0000_0120);

        // R2 R3 R6 R8 single descriptor, length 18 treated as 16
        put_desc(32'h100, INC2 | IEN, 32'h400, 32'h800, 32'd18, 32'h0);
        exp_copy(32'h400, 32'h800, 16, 1, 1);
        start(32'h100);
        wait_idle();
        chk("R3 all beats written", exp_q.size(), 0);
        rd(8'h00, v);
        chk("R5 run cleared at chain end", v[0], 1'b0);
        chk("R5 done set", v[1], 1'b1);
        chk("R8 irq flag set with enable", v[2], 1'b1);
        chk("R8 irq line high", {31'd0, irq}, 32'h1);
        rd(8'h14, v); chk("R3 length counted to zero", v, 32'h0);
        rd(8'h04, v); chk("R5 desc addr zero at end", v, 32'h0);

        // R4 write-one-to-clear
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R4 zero write keeps flags", v[2:1], 2'b11);
        wr(8'h00, 32'h6);
        rd(8'h00, v); chk("R4 flags cleared", v, 32'h0);
        chk("R4 irq low after clear", {31'd0, irq}, 32'h0);

        // R5 R8 chain of two without interrupt enable, R6 fixed source
        put_desc(32'h140, INC2, 32'h480, 32'h900, 32'd8, 32'h160);
        put_desc(32'h160, 32'h0000_0010, 32'h600, 32'hA00, 32'd12, 32'h0);
        exp_copy(32'h480, 32'h900, 8, 1, 1);
        exp_copy(32'h600, 32'hA00, 12, 0, 1);
        start(32'h140);
        wait_idle();
        chk("R5 chain fully copied", exp_q.size(), 0);
        rd(8'h00, v);
        chk("R8 no irq flag without enable", v[2], 1'b0);
        chk("R5 done after chain", v[1], 1'b1);
        chk("R8 irq line low", {31'd0, irq}, 32'h0);
        wr(8'h00, 32'h6);

        // R3 zero length descriptor
        put_desc(32'h180, IEN, 32'h400, 32'hB00, 32'd0, 32'h0);
        start(32'h180);
        wait_idle();
        rd(8'h00, v); chk("R3 zero length completes with irq", v[2:0], 3'b110);
        wr(8'h00, 32'h6);

        // R7 source pacing on line 5, R14 readback, R13 ignored write
        put_desc(32'h1A0, INC2 | 32'h0000_0400 | (32'd5 << 16), 32'h4C0, 32'hC00, 32'd8, 32'h0);
        exp_copy(32'h4C0, 32'hC00, 8, 1, 1);
        start(32'h1A0);
        repeat (40) @(negedge clk);
        chk("R7 no beats while request low", exp_q.size(), 2);
        rd(8'h00, v);
        chk("R7 held bit", v[5], 1'b1);
        chk("R7 request level bit", v[3], 1'b0);
        rd(8'h08, v); chk("R14 info readback", v, INC2 | 32'h0000_0400 | (32'd5 << 16));
        rd(8'h0C, v); chk("R14 source readback", v, 32'h4C0);
        rd(8'h10, v); chk("R14 dest readback", v, 32'hC00);
        rd(8'h14, v); chk("R14 length readback", v, 32'd8);
        rd(8'h18, v); chk("R14 stride readback", v, 32'h55);
        rd(8'h1C, v); chk("R14 next readback", v, 32'h0);
        wr(8'h04, 32'h300);
        rd(8'h04, v); chk("R13 desc addr write ignored while busy", v, 32'h1A0);
        dreq[5] = 1'b1;
        @(negedge clk);
        rd(8'h00, v); chk("R7 request level follows line", v[3], 1'b1);
        wait_idle();
        chk("R7 beats after request", exp_q.size(), 0);
        dreq[5] = 1'b0;
        wr(8'h00, 32'h6);

        // R9 pause and resume with destination paced on line 7
        put_desc(32'h1C0, INC2 | 32'h0000_0040 | (32'd7 << 16), 32'h500, 32'hD00, 32'd8, 32'h0);
        exp_copy(32'h500, 32'hD00, 8, 1, 1);
        start(32'h1C0);
        repeat (40) @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h00, v);
        chk("R9 paused bit", v[4], 1'b1);
        chk("R9 run cleared", v[0], 1'b0);
        dreq[7] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 no beats while paused", exp_q.size(), 2);
        wr(8'h00, 32'h1);
        wait_idle();
        chk("R9 resumed transfer finished", exp_q.size(), 0);
        dreq[7] = 1'b0;
        wr(8'h00, 32'h6);

        // R10 skip current descriptor
        put_desc(32'h1E0, INC2 | 32'h0000_0040 | (32'd7 << 16), 32'h400, 32'hE00, 32'd4, 32'h200);
        put_desc(32'h200, INC2, 32'h440, 32'hE40, 32'd8, 32'h0);
        exp_copy(32'h440, 32'hE40, 8, 1, 1);
        start(32'h1E0);
        repeat (40) @(negedge clk);
        wr(8'h00, 32'h4000_0001);
        wait_idle();
        chk("R10 next descriptor copied, skipped one not", exp_q.size(), 0);
        rd(8'h00, v); chk("R10 no done for skip only after chain", v[1], 1'b1);
        wr(8'h00, 32'h6);

        // R11 read error
        err_addr = 32'h520;
        put_desc(32'h220, INC2, 32'h520, 32'hF00, 32'd8, 32'h0);
        start(32'h220);
        repeat (40) @(negedge clk);
        rd(8'h20, v); chk("R11 source read error bit", v, 32'h1);
        rd(8'h00, v);
        chk("R11 cs error bit", v[8], 1'b1);
        chk("R11 channel stopped", v[0], 1'b0);
        chk("R11 irq on error", {31'd0, irq}, 32'h1);
        wr(8'h20, 32'h0);
        rd(8'h20, v); chk("R11 zero write keeps log", v, 32'h1);
        wr(8'h20, 32'h1);
        rd(8'h20, v); chk("R11 log cleared", v, 32'h0);
        chk("R11 irq low after clear", {31'd0, irq}, 32'h0);
        err_addr = 32'hFFFF_FFFF;

        // R12 soft reset while stalled
        put_desc(32'h240, INC2 | 32'h0000_0040 | (32'd7 << 16), 32'h540, 32'hF40, 32'd8, 32'h0);
        start(32'h240);
        repeat (40) @(negedge clk);
        wr(8'h00, 32'h8000_0000);
        rd(8'h00, v); chk("R12 cs cleared", v, 32'h0);
        rd(8'h04, v); chk("R12 desc addr cleared", v, 32'h0);
        rd(8'h0C, v); chk("R12 source cleared", v, 32'h0);
        rd(8'h08, v); chk("R12 info cleared", v, 32'h0);
        repeat (2) @(negedge clk);
        chk("R12 no request after reset", {31'd0, mem_req}, 32'h0);
        chk("R12 no stray writes", exp_q.size(), 0);

        report();
    end
endmodule